// File: doc/BRIEF.md
# Ordered FIFO Mailbox with Watermark Interrupts

This block carries payload words from a sending agent to a receiving agent over a set of independent FIFO channels. Each channel keeps its words in strict arrival order. The sender can queue several transfers back to back without waiting for earlier ones to be consumed, as long as the selected channel has space. Each stored word carries a flag that asks for an acknowledgement. When the receiver takes a flagged word, a per-channel acknowledge interrupt is raised toward the sender.

Every channel has its own small state machine with three states. CH_EMPTY holds no words. CH_PART holds between one word and one less than the depth. CH_FULL holds a number of words equal to the depth. The transitions are:
- CH_EMPTY to CH_PART on an accepted push, or straight to CH_FULL when the depth is 1.
- CH_PART to CH_FULL when the next occupancy reaches the depth.
- CH_PART to CH_EMPTY when the next occupancy reaches zero.
- CH_FULL to CH_PART on an accepted pop, or to CH_EMPTY when the depth is 1.
- Any state to CH_EMPTY on a flush.

Next to the state machine, a per-channel interrupt unit holds two programmable watermarks and the sticky event flags. From these it drives level-sensitive interrupts for low tide, high tide, flush, pending transfer and acknowledge. A combined output gathers the interrupts of all channels.

Top module: `mbx_fifo_mailbox`

## Requirements
- R1: Words popped from a channel come out in exactly the order they were pushed to that channel, and channels do not affect each other.
- R2: A push to a channel that has room is stored. `full_o[i]` is 1 exactly when channel i holds DEPTH words. A push to a full channel is dropped, leaves the contents unchanged and sets the sticky `ovf_o[i]` after the next rising edge.
- R3: A pop from an empty channel shows `pop_data_o` = 0 and `pop_ack_o` = 0, and changes no state: the channel stays empty and later pushes and pops behave normally.
- R4: `irq_high_o[i]` is 1 while the occupancy of channel i is greater than or equal to its high watermark. The high watermark resets to DEPTH.
- R5: `irq_low_o[i]` is 1 while the occupancy of channel i is less than or equal to its low watermark. The low watermark resets to 0. A write with `thr_we_i[i]` = 1 loads both watermarks of channel i from `thr_low_i` and `thr_high_i`.
- R6: A cycle with `flush_i[i]` = 1 has these effects. Channel i is empty after the next rising edge and the sticky `irq_flush_o[i]` is set. A push or pop to channel i in that same cycle is ignored, and `pop_data_o` shows 0.
- R7: `clr_flush_i`, `clr_ack_i` and `clr_ovf_i` clear the matching sticky bits, one bit per channel, by writing 1. If a set event and a clear happen in the same cycle, the set wins.
- R8: Each pushed word stores `push_ack_i` alongside it, and `pop_ack_o` shows that bit when the word is popped. Popping a word whose bit is 1 sets the sticky `irq_ack_o[i]` after the next rising edge.
- R9: `irq_xfer_o[i]` is 1 exactly while channel i is not empty, and `empty_o[i]` is 1 exactly while it holds no words.
- R10: `irq_comb_o` is the OR, over all channels, of the high-tide, flush, transfer and acknowledge interrupts. Low tide is not part of this OR.
- R11: `depth_o` always reads the channel depth DEPTH. After reset, all channels are empty and not full, low tide is 1 and high tide is 0 on every channel, and `irq_comb_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid_i | input | 1 | Push strobe |
| push_ch_i | input | CH_W | Channel to push to |
| push_data_i | input | DATA_W | Payload word |
| push_ack_i | input | 1 | Acknowledge requested for this word |
| full_o | output | NUM_CH | Per-channel full |
| pop_req_i | input | 1 | Pop strobe |
| pop_ch_i | input | CH_W | Channel to pop from |
| pop_data_o | output | DATA_W | Head word of the selected channel, 0 when empty |
| pop_ack_o | output | 1 | Acknowledge flag of the head word |
| empty_o | output | NUM_CH | Per-channel empty |
| thr_we_i | input | NUM_CH | Watermark write enable, one bit per channel |
| thr_low_i | input | CNT_W | Low watermark value |
| thr_high_i | input | CNT_W | High watermark value |
| flush_i | input | NUM_CH | Flush request, one bit per channel |
| clr_flush_i | input | NUM_CH | Write-one-to-clear for flush flags |
| clr_ack_i | input | NUM_CH | Write-one-to-clear for acknowledge flags |
| clr_ovf_i | input | NUM_CH | Write-one-to-clear for overflow flags |
| depth_o | output | CNT_W | Channel depth, for discovery |
| ovf_o | output | NUM_CH | Sticky overflow status |
| irq_low_o | output | NUM_CH | Low-tide interrupt |
| irq_high_o | output | NUM_CH | High-tide interrupt |
| irq_flush_o | output | NUM_CH | Flush interrupt |
| irq_xfer_o | output | NUM_CH | Receiver transfer-pending interrupt |
| irq_ack_o | output | NUM_CH | Sender acknowledge interrupt |
| irq_comb_o | output | 1 | Combined interrupt |

## Verification
The head word and its flag on `pop_data_o` and `pop_ack_o` appear in the same cycle as the pop request, because the read path has no register. Every other result appears after one rising edge. This covers occupancy, full and empty, the tides, the sticky flags and watermark loads. The bench drives inputs just after a falling edge and reads pop data one nanosecond later, before the rising edge that consumes the word. It checks registered results one nanosecond after the falling edge that follows that rising edge. A scoreboard queue per channel holds the expected words and flags, and each pop is compared against the front of its queue.

// File: rtl/mbx_fifo_pkg.sv
package mbx_fifo_pkg;

    // Occupancy state of one channel
    typedef enum logic [1:0] {
        CH_EMPTY = 2'd0,
        CH_PART  = 2'd1,
        CH_FULL  = 2'd2
    } ch_state_e;

endpackage

// File: rtl/mbx_fifo_chan.sv
module mbx_fifo_chan
    import mbx_fifo_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              push_ack_i,
    input  logic              pop_i,
    input  logic              flush_i,
    output logic [DATA_W-1:0] head_data_o,
    output logic              head_ack_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              ovf_evt_o,
    output logic              ack_evt_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    ch_state_e         st_q, st_d;
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [DATA_W-1:0] mem_data [DEPTH];
    logic              mem_ack  [DEPTH];
    logic              push_ok, pop_ok;

    // Admission: flush wins over any push or pop in the same cycle
    assign push_ok   = push_i && !flush_i && (st_q != CH_FULL);
    assign pop_ok    = pop_i  && !flush_i && (st_q != CH_EMPTY);
    assign ovf_evt_o = push_i && !flush_i && (st_q == CH_FULL);
    assign ack_evt_o = pop_ok && mem_ack[rd_ptr_q];

    always_comb begin
        if (flush_i) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_EMPTY: begin
                if (flush_i) begin
                    st_d = CH_EMPTY;
                end else if (push_ok) begin
                    st_d = (DEPTH == 1) ? CH_FULL : CH_PART;
                end
            end
            CH_PART: begin
                if (flush_i || cnt_d == '0) begin
                    st_d = CH_EMPTY;
                end else if (cnt_d == CNT_FULL) begin
                    st_d = CH_FULL;
                end
            end
            CH_FULL: begin
                if (flush_i) begin
                    st_d = CH_EMPTY;
                end else if (pop_ok) begin
                    st_d = (DEPTH == 1) ? CH_EMPTY : CH_PART;
                end
            end
            default: st_d = CH_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CH_EMPTY;
        end else begin
            st_q <= st_d;
        end
    end

    // Outputs decoded from state
    always_comb begin
        full_o  = 1'b0;
        empty_o = 1'b0;
        unique case (st_q)
            CH_EMPTY: empty_o = 1'b1;
            CH_PART:  ;
            CH_FULL:  full_o  = 1'b1;
            default:  empty_o = 1'b1;
        endcase
    end

    // Pointers and occupancy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (flush_i) begin
                wr_ptr_q <= '0;
                rd_ptr_q <= '0;
            end else begin
                if (push_ok) begin
                    wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
                end
                if (pop_ok) begin
                    rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
                end
            end
        end
    end

    // Storage: payload and acknowledge-request bit per entry
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem_data[wr_ptr_q] <= push_data_i;
            mem_ack[wr_ptr_q]  <= push_ack_i;
        end
    end

    assign head_data_o = mem_data[rd_ptr_q];
    assign head_ack_o  = mem_ack[rd_ptr_q];
    assign count_o     = cnt_q;

endmodule

// File: rtl/mbx_chan_irq.sv
module mbx_chan_irq #(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic             empty_i,
    input  logic             thr_we_i,
    input  logic [CNT_W-1:0] thr_low_i,
    input  logic [CNT_W-1:0] thr_high_i,
    input  logic             flush_evt_i,
    input  logic             ack_evt_i,
    input  logic             ovf_evt_i,
    input  logic             clr_flush_i,
    input  logic             clr_ack_i,
    input  logic             clr_ovf_i,
    output logic             irq_low_o,
    output logic             irq_high_o,
    output logic             irq_flush_o,
    output logic             irq_xfer_o,
    output logic             irq_ack_o,
    output logic             ovf_o
);

    localparam logic [CNT_W-1:0] HIGH_RST = CNT_W'(DEPTH);

    logic [CNT_W-1:0] low_q, high_q;
    logic             flush_q, ack_q, ovf_q;

    // Watermark registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q  <= '0;
            high_q <= HIGH_RST;
        end else if (thr_we_i) begin
            low_q  <= thr_low_i;
            high_q <= thr_high_i;
        end
    end

    // Sticky event flags, set has priority over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flush_q <= 1'b0;
            ack_q   <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            flush_q <= flush_evt_i | (flush_q & ~clr_flush_i);
            ack_q   <= ack_evt_i   | (ack_q   & ~clr_ack_i);
            ovf_q   <= ovf_evt_i   | (ovf_q   & ~clr_ovf_i);
        end
    end

    assign irq_low_o   = (count_i <= low_q);
    assign irq_high_o  = (count_i >= high_q);
    assign irq_flush_o = flush_q;
    assign irq_xfer_o  = ~empty_i;
    assign irq_ack_o   = ack_q;
    assign ovf_o       = ovf_q;

endmodule

// File: rtl/mbx_fifo_mailbox.sv
module mbx_fifo_mailbox #(
    parameter int NUM_CH = 4,
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid_i,
    input  logic [CH_W-1:0]   push_ch_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              push_ack_i,
    output logic [NUM_CH-1:0] full_o,
    input  logic              pop_req_i,
    input  logic [CH_W-1:0]   pop_ch_i,
    output logic [DATA_W-1:0] pop_data_o,
    output logic              pop_ack_o,
    output logic [NUM_CH-1:0] empty_o,
    input  logic [NUM_CH-1:0] thr_we_i,
    input  logic [CNT_W-1:0]  thr_low_i,
    input  logic [CNT_W-1:0]  thr_high_i,
    input  logic [NUM_CH-1:0] flush_i,
    input  logic [NUM_CH-1:0] clr_flush_i,
    input  logic [NUM_CH-1:0] clr_ack_i,
    input  logic [NUM_CH-1:0] clr_ovf_i,
    output logic [CNT_W-1:0]  depth_o,
    output logic [NUM_CH-1:0] ovf_o,
    output logic [NUM_CH-1:0] irq_low_o,
    output logic [NUM_CH-1:0] irq_high_o,
    output logic [NUM_CH-1:0] irq_flush_o,
    output logic [NUM_CH-1:0] irq_xfer_o,
    output logic [NUM_CH-1:0] irq_ack_o,
    output logic              irq_comb_o
);

    logic [DATA_W-1:0] head_data [NUM_CH];
    logic [NUM_CH-1:0] head_ack;
    logic [NUM_CH-1:0] push_sel, pop_sel, ovf_evt, ack_evt;
    logic [CNT_W-1:0]  count [NUM_CH];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign push_sel[i] = push_valid_i && (push_ch_i == CH_W'(i));
        assign pop_sel[i]  = pop_req_i    && (pop_ch_i  == CH_W'(i));

        mbx_fifo_chan #(
            .DEPTH  (DEPTH),
            .DATA_W (DATA_W),
            .CNT_W  (CNT_W)
        ) chan_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .push_i      (push_sel[i]),
            .push_data_i (push_data_i),
            .push_ack_i  (push_ack_i),
            .pop_i       (pop_sel[i]),
            .flush_i     (flush_i[i]),
            .head_data_o (head_data[i]),
            .head_ack_o  (head_ack[i]),
            .count_o     (count[i]),
            .full_o      (full_o[i]),
            .empty_o     (empty_o[i]),
            .ovf_evt_o   (ovf_evt[i]),
            .ack_evt_o   (ack_evt[i])
        );

        mbx_chan_irq #(
            .DEPTH (DEPTH),
            .CNT_W (CNT_W)
        ) irq_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .count_i     (count[i]),
            .empty_i     (empty_o[i]),
            .thr_we_i    (thr_we_i[i]),
            .thr_low_i   (thr_low_i),
            .thr_high_i  (thr_high_i),
            .flush_evt_i (flush_i[i]),
            .ack_evt_i   (ack_evt[i]),
            .ovf_evt_i   (ovf_evt[i]),
            .clr_flush_i (clr_flush_i[i]),
            .clr_ack_i   (clr_ack_i[i]),
            .clr_ovf_i   (clr_ovf_i[i]),
            .irq_low_o   (irq_low_o[i]),
            .irq_high_o  (irq_high_o[i]),
            .irq_flush_o (irq_flush_o[i]),
            .irq_xfer_o  (irq_xfer_o[i]),
            .irq_ack_o   (irq_ack_o[i]),
            .ovf_o       (ovf_o[i])
        );
    end

    // Receiver read mux: zero unless a live, non-flushed head is selected
    always_comb begin
        pop_data_o = '0;
        pop_ack_o  = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (pop_sel[i] && !empty_o[i] && !flush_i[i]) begin
                pop_data_o = head_data[i];
                pop_ack_o  = head_ack[i];
            end
        end
    end

    assign depth_o    = CNT_W'(DEPTH);
    assign irq_comb_o = |(irq_high_o | irq_flush_o | irq_xfer_o | irq_ack_o);

endmodule

// File: rtl/mbx_fifo_mailbox_chk.sv
module mbx_fifo_mailbox_chk #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 32,
    parameter int CH_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_valid_i,
    input logic [CH_W-1:0]   push_ch_i,
    input logic              pop_req_i,
    input logic [CH_W-1:0]   pop_ch_i,
    input logic [NUM_CH-1:0] flush_i,
    input logic [NUM_CH-1:0] full_o,
    input logic [NUM_CH-1:0] empty_o,
    input logic [DATA_W-1:0] pop_data_o,
    input logic              pop_ack_o,
    input logic [NUM_CH-1:0] ovf_o,
    input logic [NUM_CH-1:0] irq_flush_o,
    input logic [NUM_CH-1:0] irq_ack_o,
    input logic              irq_comb_o
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R6: a flush leaves the channel empty with its flag raised
        assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
            flush_i[i] |=> (empty_o[i] && irq_flush_o[i]));

        // R2: push into a full channel raises overflow
        assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (push_valid_i && push_ch_i == CH_W'(i) && full_o[i] && !flush_i[i])
            |=> ovf_o[i]);

        // R8: popping a flagged word raises the acknowledge interrupt
        assert_ack_on_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (pop_req_i && pop_ch_i == CH_W'(i) && !flush_i[i] && pop_ack_o)
            |=> irq_ack_o[i]);

        // R9: full and empty never together
        assert_full_empty_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !(full_o[i] && empty_o[i]));

        // R3: empty channel pops read as zero
        assert_empty_pop_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (pop_req_i && pop_ch_i == CH_W'(i) && empty_o[i])
            |-> (pop_data_o == '0 && !pop_ack_o));
    end

    // R10: a pending flush flag is always visible on the combined line
    assert_comb_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flush_o != '0) |-> irq_comb_o);

endmodule

bind mbx_fifo_mailbox mbx_fifo_mailbox_chk #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .CH_W   (CH_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_valid_i (push_valid_i),
    .push_ch_i    (push_ch_i),
    .pop_req_i    (pop_req_i),
    .pop_ch_i     (pop_ch_i),
    .flush_i      (flush_i),
    .full_o       (full_o),
    .empty_o      (empty_o),
    .pop_data_o   (pop_data_o),
    .pop_ack_o    (pop_ack_o),
    .ovf_o        (ovf_o),
    .irq_flush_o  (irq_flush_o),
    .irq_ack_o    (irq_ack_o),
    .irq_comb_o   (irq_comb_o)
);

// File: tb/mbx_fifo_mailbox_tb_top.sv
`timescale 1ns/1ps
module mbx_fifo_mailbox_tb_top;

    localparam int NUM_CH = 4;
    localparam int DEPTH  = 8;
    localparam int DATA_W = 32;
    localparam int CH_W   = 2;
    localparam int CNT_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push_valid_i = 1'b0;
    logic [CH_W-1:0]   push_ch_i = '0;
    logic [DATA_W-1:0] push_data_i = '0;
    logic              push_ack_i = 1'b0;
    logic [NUM_CH-1:0] full_o;
    logic              pop_req_i = 1'b0;
    logic [CH_W-1:0]   pop_ch_i = '0;
    logic [DATA_W-1:0] pop_data_o;
    logic              pop_ack_o;
    logic [NUM_CH-1:0] empty_o;
    logic [NUM_CH-1:0] thr_we_i = '0;
    logic [CNT_W-1:0]  thr_low_i = '0;
    logic [CNT_W-1:0]  thr_high_i = '0;
    logic [NUM_CH-1:0] flush_i = '0;
    logic [NUM_CH-1:0] clr_flush_i = '0;
    logic [NUM_CH-1:0] clr_ack_i = '0;
    logic [NUM_CH-1:0] clr_ovf_i = '0;
    logic [CNT_W-1:0]  depth_o;
    logic [NUM_CH-1:0] ovf_o, irq_low_o, irq_high_o, irq_flush_o, irq_xfer_o, irq_ack_o;
    logic              irq_comb_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Scoreboard: expected {ack, data} per channel
    logic [DATA_W:0] sb [NUM_CH][$];

    always #2.5 clk = ~clk;

    mbx_fifo_mailbox #(
        .NUM_CH (NUM_CH), .DEPTH (DEPTH), .DATA_W (DATA_W)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .push_valid_i (push_valid_i), .push_ch_i (push_ch_i),
        .push_data_i (push_data_i), .push_ack_i (push_ack_i), .full_o (full_o),
        .pop_req_i (pop_req_i), .pop_ch_i (pop_ch_i), .pop_data_o (pop_data_o),
        .pop_ack_o (pop_ack_o), .empty_o (empty_o),
        .thr_we_i (thr_we_i), .thr_low_i (thr_low_i), .thr_high_i (thr_high_i),
        .flush_i (flush_i), .clr_flush_i (clr_flush_i), .clr_ack_i (clr_ack_i),
        .clr_ovf_i (clr_ovf_i), .depth_o (depth_o), .ovf_o (ovf_o),
        .irq_low_o (irq_low_o), .irq_high_o (irq_high_o), .irq_flush_o (irq_flush_o),
        .irq_xfer_o (irq_xfer_o), .irq_ack_o (irq_ack_o), .irq_comb_o (irq_comb_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Wait to a quiet sampling point after the last rising edge
    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    // Driver: one push, scoreboard updated when the channel has room
    task automatic push(input int ch, input logic [DATA_W-1:0] d, input logic a);
        @(negedge clk);
        push_valid_i = 1'b1;
        push_ch_i    = CH_W'(ch);
        push_data_i  = d;
        push_ack_i   = a;
        if (sb[ch].size() < DEPTH) sb[ch].push_back({a, d});
        @(posedge clk);
        #1 push_valid_i = 1'b0;
    endtask

    // Monitor: one pop, compared against the scoreboard head
    task automatic pop(input int ch, input string req);
        logic [DATA_W:0] exp;
        @(negedge clk);
        pop_req_i = 1'b1;
        pop_ch_i  = CH_W'(ch);
        #1;
        if (sb[ch].size() > 0) exp = sb[ch].pop_front();
        else exp = '0;
        check(req, {31'd0, pop_ack_o, pop_data_o}, {31'd0, exp});
        @(posedge clk);
        #1 pop_req_i = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        settle();

        // R11: reset state and discovery
        check("R11 depth", depth_o, DEPTH);
        check("R11 empty", empty_o, 4'hF);
        check("R11 full", full_o, 4'h0);
        check("R5 low at reset", irq_low_o, 4'hF);
        check("R4 high at reset", irq_high_o, 4'h0);
        check("R10 comb at reset", irq_comb_o, 1'b0);

        // R1: interleaved channels, order kept
        push(0, 32'hA0, 1'b0);
        push(1, 32'hB0, 1'b0);
        push(0, 32'hA1, 1'b0);
        push(1, 32'hB1, 1'b0);
        push(0, 32'hA2, 1'b0);
        settle();
        check("R9 xfer", irq_xfer_o, 4'h3);
        check("R9 empty", empty_o, 4'hC);
        check("R10 comb with data", irq_comb_o, 1'b1);
        pop(1, "R1 ch1 first");
        pop(0, "R1 ch0 first");
        pop(0, "R1 ch0 second");
        pop(1, "R1 ch1 second");
        pop(0, "R1 ch0 third");
        settle();
        check("R9 drained", empty_o, 4'hF);

        // R2/R4: fill channel 2, overflow
        for (int k = 0; k < DEPTH; k++) push(2, 32'h200 + k, 1'b0);
        settle();
        check("R2 full", full_o, 4'h4);
        check("R4 high at depth", irq_high_o, 4'h4);
        check("R2 no ovf yet", ovf_o, 4'h0);
        push(2, 32'hDEAD, 1'b0);
        settle();
        check("R2 ovf set", ovf_o, 4'h4);
        for (int k = 0; k < DEPTH; k++) pop(2, "R2 contents after drop");
        settle();
        check("R2 empty after drain", empty_o[2], 1'b1);
        @(negedge clk) clr_ovf_i = 4'h4;
        @(posedge clk) #1 clr_ovf_i = '0;
        settle();
        check("R7 ovf cleared", ovf_o, 4'h0);

        // R3: pop on empty
        pop(3, "R3 empty pop zero");
        settle();
        check("R3 still empty", empty_o[3], 1'b1);
        check("R3 no ovf", ovf_o, 4'h0);
        push(3, 32'h33, 1'b0);
        pop(3, "R3 normal after empty pop");

        // R4/R5: programmed watermarks on channel 1
        @(negedge clk);
        thr_we_i = 4'h2; thr_low_i = 4'd2; thr_high_i = 4'd4;
        @(posedge clk) #1 thr_we_i = '0;
        settle();
        check("R5 low at zero", irq_low_o[1], 1'b1);
        for (int k = 0; k < 3; k++) push(1, 32'h100 + k, 1'b0);
        settle();
        check("R4 below high", irq_high_o[1], 1'b0);
        check("R5 above low", irq_low_o[1], 1'b0);
        push(1, 32'h103, 1'b0);
        settle();
        check("R4 at high", irq_high_o[1], 1'b1);
        pop(1, "R1 ch1 tide order");
        pop(1, "R1 ch1 tide order");
        settle();
        check("R5 at low", irq_low_o[1], 1'b1);
        check("R4 left high", irq_high_o[1], 1'b0);
        pop(1, "R1 ch1 tide order");
        pop(1, "R1 ch1 tide order");

        // R8: acknowledge request
        push(0, 32'hC0, 1'b1);
        push(0, 32'hC1, 1'b0);
        settle();
        check("R8 no ack before pop", irq_ack_o, 4'h0);
        pop(0, "R8 flagged word");
        settle();
        check("R8 ack raised", irq_ack_o, 4'h1);
        check("R10 comb ack", irq_comb_o, 1'b1);
        @(negedge clk) clr_ack_i = 4'h1;
        @(posedge clk) #1 clr_ack_i = '0;
        settle();
        check("R7 ack cleared", irq_ack_o, 4'h0);
        pop(0, "R8 unflagged word");
        settle();
        check("R8 no ack for plain word", irq_ack_o, 4'h0);

        // R6: flush with a concurrent push
        for (int k = 0; k < 3; k++) push(3, 32'h300 + k, 1'b0);
        @(negedge clk);
        flush_i = 4'h8;
        push_valid_i = 1'b1; push_ch_i = 2'd3; push_data_i = 32'hBAD;
        pop_req_i = 1'b1; pop_ch_i = 2'd3;
        #1 check("R6 pop data zero during flush", pop_data_o, 32'h0);
        @(posedge clk) #1;
        flush_i = '0; push_valid_i = 1'b0; pop_req_i = 1'b0;
        sb[3].delete();
        settle();
        check("R6 empty after flush", empty_o[3], 1'b1);
        check("R6 flush irq", irq_flush_o, 4'h8);
        check("R10 comb flush", irq_comb_o, 1'b1);
        pop(3, "R6 nothing left");

        // R7: set wins over clear, then clear alone
        @(negedge clk) begin flush_i = 4'h8; clr_flush_i = 4'h8; end
        @(posedge clk) #1 begin flush_i = '0; clr_flush_i = '0; end
        settle();
        check("R7 set wins", irq_flush_o, 4'h8);
        @(negedge clk) clr_flush_i = 4'h8;
        @(posedge clk) #1 clr_flush_i = '0;
        settle();
        check("R7 flush cleared", irq_flush_o, 4'h0);
        check("R10 comb idle", irq_comb_o, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule